// File: doc/BRIEF.md
# Timer Compare Output Waveform Generator

This block turns the event strobes of an external 16-bit timer counter into two compare output waveforms, channel A and channel B. Every clock cycle it takes a one-cycle strobe for a compare match on each channel and a strobe for the counter reaching BOTTOM. It also takes the count direction, a two-bit operating mode, a waveform high bit and, per channel, a flag saying the compare value sits at TOP. A two-bit output code selects what each channel does with those events.

Each channel produces a registered output level and a combinational override enable. When the enable is high, the pin is driven by the level. When the enable is low, the pin stays under normal port control. The counter, the prescaler and the register file sit outside the block. Mode encoding on `modeSel`: 0 = non-PWM, 1 = fast PWM, 2 = phase-correct PWM, 3 = phase-and-frequency-correct PWM.

Top module: `cmp_wave_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `outA` and `outB` to 0 at that edge.
- R2: A channel whose output code is 00 has its enable low and its level left unchanged by every strobe.
- R3: In non-PWM mode (`modeSel`=0), a match on a channel with code 01 inverts its level, code 10 drives it to 0 and code 11 drives it to 1, at the clock edge where the match strobe is high.
- R4: In fast PWM (`modeSel`=1), code 10 drives the level to 0 on a match and to 1 on BOTTOM. Code 11 drives it to 1 on a match and to 0 on BOTTOM.
- R5: In fast PWM, when a match and BOTTOM fall in the same cycle, the BOTTOM action wins.
- R6: In fast PWM, with code 10 or 11 and that channel's equals-TOP flag high, a match leaves the level unchanged. BOTTOM still acts.
- R7: In any PWM mode with code 01: if `wgmHigh`=0, both channels have their enable low and keep their level. If `wgmHigh`=1, channel A has its enable high and inverts on each match, while channel B keeps its enable low and its level.
- R8: In phase-correct PWM (`modeSel`=2), with `countUp`=1 a match applies code 10 as 0 and code 11 as 1. With `countUp`=0 it applies code 10 as 1 and code 11 as 0. BOTTOM has no effect.
- R9: `modeSel`=3 behaves exactly as `modeSel`=2.
- R10: Changing a channel's code or the mode leaves its stored level untouched. The new setting acts from the next strobe onward.
- R11: In a cycle with neither a match strobe for a channel nor, in fast PWM, a BOTTOM strobe, that channel's level holds.
- R12: Channels A and B are evaluated independently, each from its own match strobe, code and equals-TOP flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| matchA | input | 1 | Compare match strobe, channel A |
| matchB | input | 1 | Compare match strobe, channel B |
| atBottom | input | 1 | Counter-at-BOTTOM strobe |
| countUp | input | 1 | Count direction, 1 = up |
| modeSel | input | 2 | Operating mode (0 non-PWM, 1 fast, 2 phase, 3 phase-and-frequency) |
| wgmHigh | input | 1 | Waveform mode high bit |
| aEqTop | input | 1 | Channel A compare value equals TOP |
| bEqTop | input | 1 | Channel B compare value equals TOP |
| codeA | input | 2 | Output code, channel A |
| codeB | input | 2 | Output code, channel B |
| outA | output | 1 | Registered output level, channel A |
| outB | output | 1 | Registered output level, channel B |
| enA | output | 1 | Pin override enable, channel A |
| enB | output | 1 | Pin override enable, channel B |

## Verification
The output levels are due one clock edge after the cycle that carries the strobe. The enables follow the present inputs within the same cycle. The bench drives inputs on the falling edge. At each following falling edge it first advances its own model by the edge that has just passed, then compares both levels and both enables before it applies the next inputs. A result is therefore always sampled in the half-cycle where it is settled and before any new stimulus arrives.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  typedef enum logic [1:0] {
    MODE_NONPWM     = 2'd0,
    MODE_FAST       = 2'd1,
    MODE_PHASE      = 2'd2,
    MODE_PHASE_FREQ = 2'd3
  } modeT;

  typedef struct packed {
    logic doSet;
    logic doClr;
    logic doTgl;
  } actT;

  localparam int CODE_W = 2;
endpackage

// File: rtl/cwg_ctrl.sv
module cwg_ctrl
  import cwg_pkg::*;
#(
  parameter bit IS_CH_A = 1'b1
) (
  input  modeT              mode,
  input  logic              wgmHigh,
  input  logic              countUp,
  input  logic              match,
  input  logic              atBottom,
  input  logic              eqTop,
  input  logic [CODE_W-1:0] code,
  output actT               act,
  output logic              pinEn
);
  logic isPwm;
  logic tglAllowed;

  assign isPwm      = (mode != MODE_NONPWM);
  assign tglAllowed = IS_CH_A ? wgmHigh : 1'b0;

  always_comb begin
    pinEn = 1'b0;
    if (code != 2'b00) begin
      if (isPwm && code == 2'b01) pinEn = tglAllowed;
      else                        pinEn = 1'b1;
    end
  end

  always_comb begin
    act = '0;
    unique case (mode)
      MODE_NONPWM: begin
        if (match) begin
          case (code)
            2'b01:   act.doTgl = 1'b1;
            2'b10:   act.doClr = 1'b1;
            2'b11:   act.doSet = 1'b1;
            default: act = '0;
          endcase
        end
      end
      MODE_FAST: begin
        if (atBottom && code[1]) begin
          act.doSet = ~code[0];
          act.doClr = code[0];
        end else if (match) begin
          if (code == 2'b01) act.doTgl = tglAllowed;
          else if (code[1] && !eqTop) begin
            act.doSet = code[0];
            act.doClr = ~code[0];
          end
        end
      end
      default: begin
        if (match) begin
          if (code == 2'b01) act.doTgl = tglAllowed;
          else if (code[1]) begin
            act.doSet = ~(code[0] ^ countUp);
            act.doClr = code[0] ^ countUp;
          end
        end
      end
    endcase
  end

  always_comb begin
    assert ($countones(act) <= 1) else $error("AST_ONE_ACTION"); // R12
  end
endmodule

// File: rtl/cwg_dp.sv
module cwg_dp
  import cwg_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  actT [NUM_CH-1:0]  act,
  output logic [NUM_CH-1:0] lvl
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    always_ff @(posedge clk) begin
      if (rst)                  lvl[ch] <= 1'b0;
      else if (act[ch].doSet)   lvl[ch] <= 1'b1;
      else if (act[ch].doClr)   lvl[ch] <= 1'b0;
      else if (act[ch].doTgl)   lvl[ch] <= ~lvl[ch];
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (act[ch] == '0) |=> (lvl[ch] == $past(lvl[ch]))); // R11
  end
endmodule

// File: rtl/cmp_wave_gen.sv
module cmp_wave_gen
  import cwg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       matchA,
  input  logic       matchB,
  input  logic       atBottom,
  input  logic       countUp,
  input  logic [1:0] modeSel,
  input  logic       wgmHigh,
  input  logic       aEqTop,
  input  logic       bEqTop,
  input  logic [1:0] codeA,
  input  logic [1:0] codeB,
  output logic       outA,
  output logic       outB,
  output logic       enA,
  output logic       enB
);
  localparam int NUM_CH = 2;

  modeT              mode;
  actT [NUM_CH-1:0]  act;
  logic [NUM_CH-1:0] lvl;

  assign mode = modeT'(modeSel);

  cwg_ctrl #(.IS_CH_A(1'b1)) uCtrlA (
    .mode(mode), .wgmHigh(wgmHigh), .countUp(countUp), .match(matchA),
    .atBottom(atBottom), .eqTop(aEqTop), .code(codeA),
    .act(act[0]), .pinEn(enA));

  cwg_ctrl #(.IS_CH_A(1'b0)) uCtrlB (
    .mode(mode), .wgmHigh(wgmHigh), .countUp(countUp), .match(matchB),
    .atBottom(atBottom), .eqTop(bEqTop), .code(codeB),
    .act(act[1]), .pinEn(enB));

  cwg_dp #(.NUM_CH(NUM_CH)) uDp (.clk(clk), .rst(rst), .act(act), .lvl(lvl));

  assign outA = lvl[0];
  assign outB = lvl[1];

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (!outA && !outB)); // R1
  AST_DISC_NO_EN: assert property (@(posedge clk) disable iff (rst)
    (codeA == 2'b00) |-> !enA); // R2
  AST_NONPWM_CLR: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'd0 && matchA && codeA == 2'b10) |=> !outA); // R3
  AST_FAST_BOTTOM_WINS: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'd1 && atBottom && codeA == 2'b10) |=> outA); // R5
  AST_TOP_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (modeSel == 2'd1 && !atBottom && matchA && aEqTop && codeA[1])
      |=> (outA == $past(outA))); // R6
  AST_B_RESERVED: assert property (@(posedge clk) disable iff (rst)
    (modeSel != 2'd0 && codeB == 2'b01) |-> (!enB)); // R7
  AST_PHASE_UP_CLR: assert property (@(posedge clk) disable iff (rst)
    (modeSel[1] && matchA && countUp && codeA == 2'b10) |=> !outA); // R8
endmodule

// File: tb/tb_cmp_wave_gen.sv
module tb_cmp_wave_gen;
  logic clk = 1'b0;
  logic rst, matchA, matchB, atBottom, countUp, wgmHigh, aEqTop, bEqTop;
  logic [1:0] modeSel, codeA, codeB;
  logic outA, outB, enA, enB;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit expA, expB;

  always #5 clk = ~clk;

  cmp_wave_gen dut (.*);

  function automatic bit refNext(bit cur, bit isA, int mode, bit wgm, bit up,
                                 bit m, bit bot, bit eqT, int code);
    if (code == 0) return cur;
    if (mode == 0) begin
      if (!m) return cur;
      if (code == 1) return !cur;
      return (code == 3);
    end
    if (code == 1) begin
      if (isA && wgm && m) return !cur;
      return cur;
    end
    if (mode == 1) begin
      if (bot) return (code == 2);
      if (m && !eqT) return (code == 3);
      return cur;
    end
    if (!m) return cur;
    if (up) return (code == 3);
    return (code == 2);
  endfunction

  function automatic bit refEn(bit isA, int mode, bit wgm, int code);
    if (code == 0) return 0;
    if (mode != 0 && code == 1) return isA && wgm;
    return 1;
  endfunction

  task automatic cmpOne(string req, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // advance the model across the rising edge just passed, then compare
  task automatic stepCheck(string req);
    @(posedge clk);
    if (rst) begin expA = 0; expB = 0; end
    else begin
      expA = refNext(expA, 1, modeSel, wgmHigh, countUp, matchA, atBottom, aEqTop, codeA);
      expB = refNext(expB, 0, modeSel, wgmHigh, countUp, matchB, atBottom, bEqTop, codeB);
    end
    @(negedge clk);
    cmpOne(req, "outA", outA, expA);
    cmpOne(req, "outB", outB, expB);
    cmpOne(req, "enA", enA, refEn(1, modeSel, wgmHigh, codeA));
    cmpOne(req, "enB", enB, refEn(0, modeSel, wgmHigh, codeB));
  endtask

  task automatic quiet();
    matchA = 0; matchB = 0; atBottom = 0;
  endtask

  task automatic ev(string req, bit mA, bit mB, bit bot);
    matchA = mA; matchB = mB; atBottom = bot;
    stepCheck(req);
    quiet();
  endtask

  initial begin
    rst = 1; quiet(); countUp = 1; modeSel = 0; wgmHigh = 0;
    aEqTop = 0; bEqTop = 0; codeA = 0; codeB = 0;
    expA = 0; expB = 0;
    @(negedge clk);
    stepCheck("R1");
    rst = 0;
    // R2: disconnected channels ignore every strobe
    ev("R2", 1, 1, 1);
    // R3: non-PWM set / clear / toggle
    codeA = 2'b11; codeB = 2'b01;
    ev("R3", 1, 1, 0);
    codeA = 2'b10; ev("R3", 1, 0, 0);
    codeA = 2'b01; ev("R3", 1, 1, 0); ev("R3", 1, 0, 0);
    // R11: hold with no strobe
    ev("R11", 0, 0, 0); ev("R11", 0, 0, 1);
    // R4: fast PWM non-inverting and inverting
    modeSel = 1; codeA = 2'b10; codeB = 2'b11;
    ev("R4", 0, 0, 1); ev("R4", 1, 1, 0); ev("R4", 0, 0, 1);
    // R5: BOTTOM wins over match
    ev("R5", 1, 1, 1);
    // R6: match ignored at TOP, BOTTOM still acts
    aEqTop = 1; ev("R6", 1, 0, 0); ev("R6", 0, 0, 1); aEqTop = 0;
    // R7: code 01 in PWM
    codeA = 2'b01; codeB = 2'b01; wgmHigh = 0;
    ev("R7", 1, 1, 0);
    wgmHigh = 1; ev("R7", 1, 1, 0); ev("R7", 1, 1, 0);
    // R8: phase-correct direction
    modeSel = 2; codeA = 2'b10; codeB = 2'b11; countUp = 1;
    ev("R8", 1, 1, 0); ev("R8", 0, 0, 1);
    countUp = 0; ev("R8", 1, 1, 0);
    // R9: mode 3 same as 2
    modeSel = 3; countUp = 1; ev("R9", 1, 1, 0);
    countUp = 0; ev("R9", 1, 1, 0);
    // R10: mode/code change leaves levels
    codeA = 2'b01; codeB = 2'b10; modeSel = 0; ev("R10", 0, 0, 0);
    modeSel = 1; ev("R10", 0, 0, 0);
    // R12: channels independent
    modeSel = 0; codeA = 2'b11; codeB = 2'b11; ev("R12", 0, 1, 0); ev("R12", 1, 0, 0);
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      rst      = ($urandom_range(0, 99) == 0);
      matchA   = $urandom_range(0, 1);
      matchB   = $urandom_range(0, 1);
      atBottom = ($urandom_range(0, 3) == 0);
      countUp  = $urandom_range(0, 1);
      modeSel  = 2'($urandom_range(0, 3));
      wgmHigh  = $urandom_range(0, 1);
      aEqTop   = ($urandom_range(0, 3) == 0);
      bEqTop   = ($urandom_range(0, 3) == 0);
      codeA    = 2'($urandom_range(0, 3));
      codeB    = 2'($urandom_range(0, 3));
      stepCheck("R12");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule